// File: doc/BRIEF.md
# Microsecond Time Base with Compare Alarms

This block is a peripheral on an APB bus. It keeps a 64-bit running time value that advances once per pulse of an external one-microsecond strobe. Software can load and read the 64-bit value through two 32-bit halves without tearing. Four compare alarms watch the low 32 bits of the time value. Each one raises an interrupt when it matches and then disarms itself.

Each alarm's interrupt line is the raw event bit gated by an enable bit, with a per-alarm force bit ORed in. Counting stops while a software pause bit is set. It also stops while a halt input from either of two processors is active, if the enable bit for that processor is set. The tick prescaler and any clock-domain crossing belong to the surrounding logic.

Top module: `usec_timer_apb`

## Requirements
- R1: After reset every readable location returns 0, except the halt-enable word at offset 0x2C, which reads 0x6 (bits 2:1 set). All interrupt lines are low.
- R2: Every transfer finishes in its access cycle with `pready`=1 and `pslverr`=0. A read of an unmapped word returns 0. Writes to read-only offsets 0x08, 0x0C, 0x24, 0x28 and 0x40 change nothing.
- R3: On each clock with `tick_i`=1, with no pause condition and no commit, the 64-bit time value rises by exactly one. It does not change on any other clock.
- R4: While bit 0 of offset 0x30 is 1, counting stops. Counting also stops while `dbg_halt_i[k]` is 1 and bit k+1 of offset 0x2C is 1, for k = 0 and 1.
- R5: A write to 0x04 only loads a holding word. A write to 0x00 loads the time value with {written word, holding word} in that cycle, and this load wins over a tick in the same cycle.
- R6: A read of 0x0C returns the live low half and copies the live high half into a snapshot. A read of 0x08 returns that snapshot. Reads of 0x24 and 0x28 return the live high and low halves and leave the snapshot untouched.
- R7: A write to alarm k (offset 0x10 + 4k) stores the target, which reads back at that offset, and sets bit k of the armed word at 0x20.
- R8: An armed alarm whose target equals the low 32 bits of the time value clears its armed bit and sets bit k of the raw event word at 0x34 on the next clock.
- R9: Writing 1 to bit k of 0x20 disarms alarm k without raising its event. Bits written as 0 have no effect.
- R10: Writing 1 to bit k of 0x34 clears that raw bit. A firing in the same clock keeps the bit set.
- R11: Each `irq_o[k]` and bit k of the status word at 0x40 equal (raw AND enable at 0x38) OR force at 0x3C.
- R12: A write to alarm k in the same clock that alarm k matches wins. The alarm stays armed with the new target and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| tick_i | input | 1 | One-microsecond strobe |
| dbg_halt_i | input | 2 | Per-processor debug-halt indications |
| irq_o | output | NUM_ALARM | Per-alarm interrupt lines |

## Verification
The bench goes after four corner cases.
- A high-half load in the same cycle as a tick. A design that gave the increment priority would end one above the loaded value.
- A carry into the high half between the low read and the snapshot read. A design that returned the live high word would show the new value instead of the snapshot.
- An alarm rewrite timed to land on the cycle its old target matches. If the match won, the alarm would come out disarmed with a stray event.
- A raw-bit clear and a disarm request. A design that mixed up write-one semantics would clear or disarm the wrong bits, or raise an event on cancel.

Random traffic, with ticks and halt inputs changing, runs against a bench reference model of every register. The model exercises the pause and halt gating.

// File: rtl/ustmr_pkg.sv
package ustmr_pkg;
    localparam int unsigned DW = 32;

    localparam int unsigned OFS_HI_LOAD  = 'h00;
    localparam int unsigned OFS_LO_LOAD  = 'h04;
    localparam int unsigned OFS_HI_SNAP  = 'h08;
    localparam int unsigned OFS_LO_READ  = 'h0C;
    localparam int unsigned OFS_ALM_BASE = 'h10;
    localparam int unsigned OFS_ARMED    = 'h20;
    localparam int unsigned OFS_HI_LIVE  = 'h24;
    localparam int unsigned OFS_LO_LIVE  = 'h28;
    localparam int unsigned OFS_HALT_EN  = 'h2C;
    localparam int unsigned OFS_PAUSE    = 'h30;
    localparam int unsigned OFS_RAW      = 'h34;
    localparam int unsigned OFS_EN       = 'h38;
    localparam int unsigned OFS_FORCE    = 'h3C;
    localparam int unsigned OFS_STATUS   = 'h40;

    typedef struct packed {
        logic       pause;
        logic [1:0] halt_en;
    } ctl_t;
endpackage

// File: rtl/ustmr_counter.sv
module ustmr_counter #(
    parameter int unsigned HALF_W = 32,
    localparam int unsigned CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              halt,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic              lo_rd,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic [HALF_W-1:0] snap_hi
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [HALF_W-1:0] hold;
        logic [HALF_W-1:0] snap;
    } cstate_t;

    cstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lo_wr) st_d.hold = wdata;
        if (hi_wr)
            st_d.cnt = {wdata, st_q.hold};
        else if (tick && !halt)
            st_d.cnt = st_q.cnt + CNT_W'(1);
        if (lo_rd) st_d.snap = st_q.cnt[CNT_W-1:HALF_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign snap_hi = st_q.snap;
endmodule

// File: rtl/ustmr_alarms.sv
module ustmr_alarms #(
    parameter int unsigned NUM_ALARM = 4,
    parameter int unsigned W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         cnt_lo,
    input  logic [NUM_ALARM-1:0] wr_sel,
    input  logic [NUM_ALARM-1:0] disarm,
    input  logic [W-1:0]         wdata,
    output logic [W-1:0]         tgt [NUM_ALARM],
    output logic [NUM_ALARM-1:0] armed,
    output logic [NUM_ALARM-1:0] fire
);
    typedef struct packed {
        logic [W-1:0] tgt;
        logic         armed;
    } alm_t;

    for (genvar i = 0; i < NUM_ALARM; i++) begin : g_alm
        alm_t a_d, a_q;

        assign fire[i] = a_q.armed && (a_q.tgt == cnt_lo) && !wr_sel[i];

        always_comb begin
            a_d = a_q;
            if (wr_sel[i]) begin
                a_d.tgt   = wdata;
                a_d.armed = 1'b1;
            end else if (fire[i] || disarm[i]) begin
                a_d.armed = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) a_q <= '0;
            else        a_q <= a_d;
        end

        assign tgt[i]   = a_q.tgt;
        assign armed[i] = a_q.armed;
    end
endmodule

// File: rtl/ustmr_irq.sv
module ustmr_irq #(
    parameter int unsigned NUM_ALARM = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_ALARM-1:0] fire,
    input  logic                 clr_wr,
    input  logic                 en_wr,
    input  logic                 frc_wr,
    input  logic [NUM_ALARM-1:0] wdata,
    output logic [NUM_ALARM-1:0] raw,
    output logic [NUM_ALARM-1:0] en,
    output logic [NUM_ALARM-1:0] frc,
    output logic [NUM_ALARM-1:0] status
);
    typedef struct packed {
        logic [NUM_ALARM-1:0] raw;
        logic [NUM_ALARM-1:0] en;
        logic [NUM_ALARM-1:0] frc;
    } istate_t;

    istate_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.raw = (st_q.raw & ~(clr_wr ? wdata : '0)) | fire;
        if (en_wr)  st_d.en  = wdata;
        if (frc_wr) st_d.frc = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw    = st_q.raw;
    assign en     = st_q.en;
    assign frc    = st_q.frc;
    assign status = (st_q.raw & st_q.en) | st_q.frc;
endmodule

// File: rtl/usec_timer_apb.sv
module usec_timer_apb
    import ustmr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_ALARM = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [31:0]          pwdata,
    output logic [31:0]          prdata,
    output logic                 pready,
    output logic                 pslverr,
    input  logic                 tick_i,
    input  logic [1:0]           dbg_halt_i,
    output logic [NUM_ALARM-1:0] irq_o
);
    localparam int unsigned CNT_W = 2 * DW;

    logic                 wr_acc, rd_acc;
    logic                 hi_commit, lo_wr, lo_rd, halt;
    logic [CNT_W-1:0]     cnt;
    logic [DW-1:0]        snap_hi;
    logic [NUM_ALARM-1:0] alm_wr, disarm_v, armed, fire;
    logic [NUM_ALARM-1:0] raw, en, frc, status;
    logic [DW-1:0]        tgt [NUM_ALARM];
    ctl_t                 ctl_d, ctl_q;
    logic [DW-1:0]        rdata;

    assign wr_acc    = psel && penable && pwrite;
    assign rd_acc    = psel && penable && !pwrite;
    assign hi_commit = wr_acc && (paddr == ADDR_W'(OFS_HI_LOAD));
    assign lo_wr     = wr_acc && (paddr == ADDR_W'(OFS_LO_LOAD));
    assign lo_rd     = rd_acc && (paddr == ADDR_W'(OFS_LO_READ));
    assign halt      = ctl_q.pause || |(ctl_q.halt_en & dbg_halt_i);

    for (genvar i = 0; i < NUM_ALARM; i++) begin : g_sel
        assign alm_wr[i]   = wr_acc && (paddr == ADDR_W'(OFS_ALM_BASE + 4 * i));
        assign disarm_v[i] = wr_acc && (paddr == ADDR_W'(OFS_ARMED)) && pwdata[i];
    end

    ustmr_counter #(.HALF_W(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_i), .halt(halt),
        .lo_wr(lo_wr), .hi_wr(hi_commit), .lo_rd(lo_rd),
        .wdata(pwdata), .cnt(cnt), .snap_hi(snap_hi)
    );

    ustmr_alarms #(.NUM_ALARM(NUM_ALARM), .W(DW)) u_alm (
        .clk(clk), .rst_n(rst_n), .cnt_lo(cnt[DW-1:0]),
        .wr_sel(alm_wr), .disarm(disarm_v), .wdata(pwdata),
        .tgt(tgt), .armed(armed), .fire(fire)
    );

    ustmr_irq #(.NUM_ALARM(NUM_ALARM)) u_irq (
        .clk(clk), .rst_n(rst_n), .fire(fire),
        .clr_wr(wr_acc && (paddr == ADDR_W'(OFS_RAW))),
        .en_wr(wr_acc && (paddr == ADDR_W'(OFS_EN))),
        .frc_wr(wr_acc && (paddr == ADDR_W'(OFS_FORCE))),
        .wdata(pwdata[NUM_ALARM-1:0]),
        .raw(raw), .en(en), .frc(frc), .status(status)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_acc && (paddr == ADDR_W'(OFS_PAUSE)))   ctl_d.pause   = pwdata[0];
        if (wr_acc && (paddr == ADDR_W'(OFS_HALT_EN))) ctl_d.halt_en = pwdata[2:1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{pause: 1'b0, halt_en: 2'b11};
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rdata = '0;
        case (paddr)
            ADDR_W'(OFS_HI_SNAP): rdata = snap_hi;
            ADDR_W'(OFS_LO_READ): rdata = cnt[DW-1:0];
            ADDR_W'(OFS_ARMED):   rdata = DW'(armed);
            ADDR_W'(OFS_HI_LIVE): rdata = cnt[CNT_W-1:DW];
            ADDR_W'(OFS_LO_LIVE): rdata = cnt[DW-1:0];
            ADDR_W'(OFS_HALT_EN): rdata = DW'({ctl_q.halt_en, 1'b0});
            ADDR_W'(OFS_PAUSE):   rdata = DW'(ctl_q.pause);
            ADDR_W'(OFS_RAW):     rdata = DW'(raw);
            ADDR_W'(OFS_EN):      rdata = DW'(en);
            ADDR_W'(OFS_FORCE):   rdata = DW'(frc);
            ADDR_W'(OFS_STATUS):  rdata = DW'(status);
            default: begin
                for (int i = 0; i < NUM_ALARM; i++)
                    if (paddr == ADDR_W'(OFS_ALM_BASE + 4 * i)) rdata = tgt[i];
            end
        endcase
    end

    assign prdata  = rd_acc ? rdata : '0;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq_o   = status;
endmodule

// File: rtl/ustmr_sva.sv
module ustmr_sva #(
    parameter int unsigned NUM_ALARM = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic                 halt,
    input logic                 hi_commit,
    input logic [31:0]          wdata,
    input logic [63:0]          cnt,
    input logic [NUM_ALARM-1:0] alm_wr,
    input logic [NUM_ALARM-1:0] armed,
    input logic [NUM_ALARM-1:0] fire,
    input logic [NUM_ALARM-1:0] raw
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !halt && !hi_commit |=> cnt == $past(cnt) + 64'd1); // R3

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick || halt) && !hi_commit |=> $stable(cnt)); // R4

    AST_COMMIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        hi_commit |=> cnt[63:32] == $past(wdata)); // R5

    for (genvar i = 0; i < NUM_ALARM; i++) begin : g_chk
        AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            alm_wr[i] |=> armed[i]); // R7

        AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> !armed[i] && raw[i]); // R8

        AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |-> armed[i] && !alm_wr[i]); // R12
    end
endmodule

bind usec_timer_apb ustmr_sva #(.NUM_ALARM(NUM_ALARM)) sva_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .halt(halt),
    .hi_commit(hi_commit), .wdata(pwdata), .cnt(cnt),
    .alm_wr(alm_wr), .armed(armed), .fire(fire), .raw(raw)
);

// File: tb/usec_timer_apb_tb_top.sv
module usec_timer_apb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        tick_i = 1'b0;
    logic [1:0]  dbg_halt_i = 2'b00;
    logic [3:0]  irq_o;

    int n_chk = 0, n_fail = 0, cyc = 0, tick_ctl = 0;

    // reference model state
    logic [63:0] m_cnt;
    logic [31:0] m_hold, m_snap;
    logic [31:0] m_tgt [4];
    logic [3:0]  m_armed, m_raw, m_en, m_frc;
    logic        m_pause;
    logic [1:0]  m_hen;

    usec_timer_apb dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .tick_i(tick_i),
        .dbg_halt_i(dbg_halt_i), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin : model
        logic wr, rd;
        logic [3:0] f;
        logic [3:0] raw_n;
        if (!rst_n) begin
            m_cnt = '0; m_hold = '0; m_snap = '0;
            for (int i = 0; i < 4; i++) m_tgt[i] = '0;
            m_armed = '0; m_raw = '0; m_en = '0; m_frc = '0;
            m_pause = 1'b0; m_hen = 2'b11;
        end else begin
            wr = psel && penable && pwrite;
            rd = psel && penable && !pwrite;
            for (int i = 0; i < 4; i++)
                f[i] = m_armed[i] && (m_tgt[i] == m_cnt[31:0])
                       && !(wr && paddr == 8'(8'h10 + 4 * i));
            raw_n = (m_raw & ~((wr && paddr == 8'h34) ? pwdata[3:0] : 4'h0)) | f;
            if (rd && paddr == 8'h0C) m_snap = m_cnt[63:32];
            if (wr && paddr == 8'h00) m_cnt = {pwdata, m_hold};
            else if (tick_i && !(m_pause || |(m_hen & dbg_halt_i))) m_cnt = m_cnt + 64'd1;
            if (wr && paddr == 8'h04) m_hold = pwdata;
            for (int i = 0; i < 4; i++) begin
                if (wr && paddr == 8'(8'h10 + 4 * i)) begin
                    m_tgt[i] = pwdata; m_armed[i] = 1'b1;
                end else if (f[i] || (wr && paddr == 8'h20 && pwdata[i]))
                    m_armed[i] = 1'b0;
            end
            m_raw = raw_n;
            if (wr && paddr == 8'h38) m_en = pwdata[3:0];
            if (wr && paddr == 8'h3C) m_frc = pwdata[3:0];
            if (wr && paddr == 8'h30) m_pause = pwdata[0];
            if (wr && paddr == 8'h2C) m_hen = pwdata[2:1];
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h08: return m_snap;
            8'h0C, 8'h28: return m_cnt[31:0];
            8'h10: return m_tgt[0];
            8'h14: return m_tgt[1];
            8'h18: return m_tgt[2];
            8'h1C: return m_tgt[3];
            8'h20: return {28'h0, m_armed};
            8'h24: return m_cnt[63:32];
            8'h2C: return {29'h0, m_hen, 1'b0};
            8'h30: return {31'h0, m_pause};
            8'h34: return {28'h0, m_raw};
            8'h38: return {28'h0, m_en};
            8'h3C: return {28'h0, m_frc};
            8'h40: return {28'h0, (m_raw & m_en) | m_frc};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h08, 8'h0C, 8'h24, 8'h28: return "R6";
            8'h10, 8'h14, 8'h18, 8'h1C: return "R7";
            8'h20: return "R8";
            8'h2C, 8'h30: return "R4";
            8'h34: return "R10";
            8'h38, 8'h3C, 8'h40: return "R11";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic drive_tick();
        case (tick_ctl)
            0: tick_i = 1'b0;
            1: tick_i = 1'b1;
            3: begin tick_i = 1'b1; tick_ctl = 0; end
            default: tick_i = 1'($urandom % 2);
        endcase
    endtask

    task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] d, input string tag);
        logic [31:0] e;
        @(negedge clk);
        drive_tick();
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        drive_tick();
        penable = 1'b1;
        #1;
        chk(pready === 1'b1 && pslverr === 1'b0, "R2", {30'h0, pready, pslverr}, 32'h2);
        chk(irq_o === ((m_raw & m_en) | m_frc), "R11", {28'h0, irq_o}, {28'h0, (m_raw & m_en) | m_frc});
        if (!wr) begin
            e = exp_read(a);
            chk(prdata === e, tag, prdata, e);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            drive_tick();
            psel = 1'b0; penable = 1'b0;
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
        end
    end

    initial begin
        logic [7:0] ra;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values of every mapped word and the interrupt lines
        for (int a = 0; a <= 'h40; a += 4) apb(1'b0, 8'(a), 0, "R1");
        chk(irq_o === 4'h0, "R1", {28'h0, irq_o}, 32'h0);

        // R2: unmapped reads and ignored writes to read-only words
        apb(1'b0, 8'h44, 0, "R2");
        apb(1'b0, 8'hFC, 0, "R2");
        apb(1'b1, 8'h24, 32'hDEAD_BEEF, "R2");
        apb(1'b1, 8'h40, 32'hF, "R2");
        apb(1'b0, 8'h24, 0, "R2");
        apb(1'b0, 8'h40, 0, "R2");

        // R3: steady counting, both halt enables cleared
        apb(1'b1, 8'h2C, 32'h0, "R4");
        tick_ctl = 1;
        apb(1'b0, 8'h28, 0, "R3");
        idle(7);
        apb(1'b0, 8'h28, 0, "R3");

        // R4: halt input 0 gated by its enable, then software pause
        apb(1'b1, 8'h2C, 32'h2, "R4");
        dbg_halt_i = 2'b01;
        apb(1'b0, 8'h28, 0, "R4");
        idle(5);
        apb(1'b0, 8'h28, 0, "R4");
        dbg_halt_i = 2'b00;
        apb(1'b1, 8'h30, 32'h1, "R4");
        idle(4);
        apb(1'b0, 8'h28, 0, "R4");
        apb(1'b1, 8'h30, 32'h0, "R4");

        // R5: high write commits with a tick in the same cycle
        apb(1'b1, 8'h04, 32'hFFFF_FFF8, "R5");
        apb(1'b1, 8'h00, 32'h0000_0001, "R5");
        apb(1'b0, 8'h24, 0, "R5");
        apb(1'b0, 8'h28, 0, "R5");

        // R6: snapshot survives a carry into the high half
        apb(1'b0, 8'h0C, 0, "R6");
        idle(12);
        apb(1'b0, 8'h24, 0, "R6");
        apb(1'b0, 8'h08, 0, "R6");

        // R8: alarm fires then disarms
        tick_ctl = 0;
        apb(1'b1, 8'h38, 32'hF, "R11");
        apb(1'b1, 8'h14, m_cnt[31:0] + 32'd3, "R7");
        tick_ctl = 1;
        idle(8);
        tick_ctl = 0;
        apb(1'b0, 8'h20, 0, "R8");
        apb(1'b0, 8'h34, 0, "R8");
        apb(1'b0, 8'h40, 0, "R11");

        // R10: write-one clear of the raw bit, zero bits ignored
        apb(1'b1, 8'h34, 32'h1, "R10");
        apb(1'b0, 8'h34, 0, "R10");
        apb(1'b1, 8'h34, 32'h2, "R10");
        apb(1'b0, 8'h34, 0, "R10");

        // R9: disarm without an event
        apb(1'b1, 8'h18, m_cnt[31:0] + 32'd2, "R7");
        apb(1'b1, 8'h1C, m_cnt[31:0] + 32'd2, "R7");
        apb(1'b1, 8'h20, 32'h4, "R9");
        tick_ctl = 1;
        idle(6);
        tick_ctl = 0;
        apb(1'b0, 8'h20, 0, "R9");
        apb(1'b0, 8'h34, 0, "R9");
        apb(1'b1, 8'h34, 32'hF, "R10");

        // R11: force bit drives the line with enable cleared
        apb(1'b1, 8'h38, 32'h0, "R11");
        apb(1'b1, 8'h3C, 32'h5, "R11");
        apb(1'b0, 8'h40, 0, "R11");
        apb(1'b1, 8'h3C, 32'h0, "R11");

        // R12: rewrite lands on the matching cycle
        apb(1'b1, 8'h10, m_cnt[31:0] + 32'd1, "R12");
        tick_ctl = 3;
        apb(1'b1, 8'h10, 32'h0000_0020, "R12");
        apb(1'b0, 8'h20, 0, "R12");
        apb(1'b0, 8'h34, 0, "R12");
        apb(1'b0, 8'h10, 0, "R12");

        // constrained random traffic
        tick_ctl = 2;
        for (int n = 0; n < 3000; n++) begin
            dbg_halt_i = 2'($urandom % 4);
            ra = 8'(($urandom % 18) * 4);
            case ($urandom % 10)
                0: apb(1'b1, 8'h04, $urandom % 4 == 0 ? $urandom : m_cnt[31:0] + ($urandom % 16), "R5");
                1: apb(1'b1, 8'h00, $urandom % 4, "R5");
                2, 3: apb(1'b1, 8'(8'h10 + 4 * ($urandom % 4)), m_cnt[31:0] + ($urandom % 24), "R7");
                4: apb(1'b1, 8'(8'h20 + 8'h14 * ($urandom % 2)), $urandom % 16, "R9");
                5: apb(1'b1, 8'(8'h2C + 4 * ($urandom % 4)), $urandom % 4 == 0 ? $urandom : 0, "R11");
                default: apb(1'b0, ra, 0, tag_of(ra));
            endcase
        end
        idle(2);
        summary();
    end
endmodule